// File: doc/BRIEF.md
# Three-Channel Table-Coded Clock-Enable Divider

This block takes one parent clock and derives three independent clock-enable streams from it: a primary channel and two secondary channels. Each stream carries a single-cycle pulse once every N parent cycles. N is selected by a 4-bit code, and the three codes share one 12-bit control word. The codes do not map linearly onto divisors. They pass through fixed lookup tables, and these tables include divisors that are not powers of two, such as 3, 10, 18, 36 and 48. The primary channel uses one table and both secondary channels use a second table.

Software writes the control word through a simple write strobe and reads it back unchanged. A write that carries a code absent from a channel's table leaves that channel on its previous divisor. A new divisor never cuts short the period already under way: it is adopted at the next pulse. An elaboration option removes the lowest secondary-table entry from both secondary channels.

Top module: `tri_table_clkdiv`

## Requirements
- R1: `cfg_rdata` always shows the last word written through `cfg_we`/`cfg_wdata`, bit for bit, including invalid codes; after reset it reads 12'hBBB.
- R2: The primary code is bits 11:8 of the control word, secondary channel 0 is bits 7:4, and secondary channel 1 is bits 3:0.
- R3: Primary codes select these divisors: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. Codes 9 and 12 to 15 are invalid.
- R4: Secondary codes select these divisors: 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→10. Codes 0 to 3, 9 and 13 to 15 are invalid.
- R5: With `SEC_DROP_LOW`=1, code 4 is invalid on both secondary channels. The primary channel and all other codes are unaffected.
- R6: When a channel receives an invalid code, it keeps dividing by its last valid divisor.
- R7: Each enable output is high for exactly one parent cycle in every N cycles, where N is that channel's current divisor.
- R8: A newly written divisor takes effect only after the pulse that ends the current period, so the period in progress completes with the old divisor.
- R9: Reset clears every counter and loads divisor 48 on all channels. The first pulse of each channel is high in the cycle after the 47th rising edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 12 | Control word to write |
| cfg_rdata | output | 12 | Current control word, raw |
| en_pri | output | 1 | Primary channel enable pulse |
| en_sec0 | output | 1 | Secondary channel 0 enable pulse |
| en_sec1 | output | 1 | Secondary channel 1 enable pulse |

## Verification
A write is captured on one rising edge, so the readback is checked at the falling edge right after that edge. A new divisor appears only after the pulse that closes the running period, which comes at most 48 edges later. The bench therefore waits 50 cycles after every write, then records pulse positions for 150 cycles and requires every gap between pulses to equal the expected divisor. For reset and mid-period changes, the bench counts falling edges from reset release: the first pulse is due at count 47, and after a write of divisor 2 during that period the next primary pulse is due at count 49.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

   typedef struct packed {
      logic       ok;
      logic [7:0] div;
   } tcd_dec_t;

   typedef enum logic {TCD_PRIMARY = 1'b0, TCD_SECONDARY = 1'b1} tcd_kind_e;

   // Primary table: dense from 2, with holes at 9 and above 11.
   function automatic tcd_dec_t tcd_primary_lut(input logic [3:0] code);
      tcd_dec_t r;
      r.ok = 1'b1;
      case (code)
         4'd0:    r.div = 8'd2;
         4'd1:    r.div = 8'd3;
         4'd2:    r.div = 8'd4;
         4'd3:    r.div = 8'd6;
         4'd4:    r.div = 8'd8;
         4'd5:    r.div = 8'd12;
         4'd6:    r.div = 8'd16;
         4'd7:    r.div = 8'd18;
         4'd8:    r.div = 8'd24;
         4'd10:   r.div = 8'd36;
         4'd11:   r.div = 8'd48;
         default: begin r.ok = 1'b0; r.div = 8'd0; end
      endcase
      return r;
   endfunction

   // Secondary table: starts at code 4, code 12 gives divide-by-10.
   function automatic tcd_dec_t tcd_secondary_lut(input logic [3:0] code,
                                                  input logic       drop_low);
      tcd_dec_t r;
      r.ok = 1'b1;
      case (code)
         4'd4: begin
            r.ok  = !drop_low;
            r.div = drop_low ? 8'd0 : 8'd8;
         end
         4'd5:    r.div = 8'd12;
         4'd6:    r.div = 8'd16;
         4'd7:    r.div = 8'd18;
         4'd8:    r.div = 8'd24;
         4'd10:   r.div = 8'd36;
         4'd11:   r.div = 8'd48;
         4'd12:   r.div = 8'd10;
         default: begin r.ok = 1'b0; r.div = 8'd0; end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tcd_lut.sv
module tcd_lut #(
   parameter tcd_pkg::tcd_kind_e KIND     = tcd_pkg::TCD_PRIMARY,
   parameter bit                 DROP_LOW = 1'b0,
   parameter int                 CODE_W   = 4,
   parameter int                 DIV_W    = 6
) (
   input  logic [CODE_W-1:0] code,
   output logic              ok,
   output logic [DIV_W-1:0]  div
);
   import tcd_pkg::*;

   tcd_dec_t dec;

   generate
      if (KIND == TCD_PRIMARY) begin : g_pri
         always_comb dec = tcd_primary_lut(code);
      end else begin : g_sec
         always_comb dec = tcd_secondary_lut(code, DROP_LOW);
      end
   endgenerate

   assign ok  = dec.ok;
   assign div = DIV_W'(dec.div);

   // A valid entry never decodes to a divisor below 2.
   always_comb begin
      if (ok) a_min_div_r7: assert (div >= DIV_W'(2));
   end

endmodule

// File: rtl/tcd_chan.sv
module tcd_chan #(
   parameter int              DIV_W   = 6,
   parameter logic [DIV_W-1:0] RST_DIV = DIV_W'(48)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             ld_ok,
   input  logic [DIV_W-1:0] ld_div,
   output logic             tick
);

   logic [DIV_W-1:0] tgt_q;   // last valid requested divisor
   logic [DIV_W-1:0] cur_q;   // divisor of the running period
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == cur_q - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= RST_DIV;
         cur_q <= RST_DIV;
         cnt_q <= '0;
      end else begin
         if (load && ld_ok) tgt_q <= ld_div;
         if (tick) begin
            cnt_q <= '0;
            cur_q <= tgt_q;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end
   end

   p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < cur_q);

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0) && !tick);

   p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cur_q));

   p_keep_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ld_ok) |=> $stable(tgt_q));

endmodule

// File: rtl/tri_table_clkdiv.sv
module tri_table_clkdiv #(
   parameter int         CODE_W       = 4,
   parameter int         DIV_W        = 6,
   parameter bit         SEC_DROP_LOW = 1'b0,
   parameter logic [3:0] RST_CODE     = 4'd11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [3*CODE_W-1:0]    cfg_wdata,
   output logic [3*CODE_W-1:0]    cfg_rdata,
   output logic                   en_pri,
   output logic                   en_sec0,
   output logic                   en_sec1
);
   import tcd_pkg::*;

   localparam int NUM_CH = 3;
   localparam int REG_W  = NUM_CH * CODE_W;
   localparam logic [REG_W-1:0] RST_WORD = {NUM_CH{CODE_W'(RST_CODE)}};

   generate
      if (CODE_W != 4) begin : g_bad_code_w
         $error("tri_table_clkdiv: CODE_W must be 4");
      end
      if (DIV_W < 6 || DIV_W > 8) begin : g_bad_div_w
         $error("tri_table_clkdiv: DIV_W must be 6..8 to hold divisor 48");
      end
   endgenerate

   logic [REG_W-1:0]  cfg_q;
   logic [NUM_CH-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= RST_WORD;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   assign cfg_rdata = cfg_q;

   // Channel 0 (primary) owns the top field; the rest follow downwards.
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         localparam tcd_kind_e KIND = (i == 0) ? TCD_PRIMARY : TCD_SECONDARY;
         localparam tcd_dec_t  RST_DEC = (i == 0) ? tcd_primary_lut(RST_CODE)
                                        : tcd_secondary_lut(RST_CODE, SEC_DROP_LOW);
         localparam int        LSB = (NUM_CH - 1 - i) * CODE_W;

         logic             ld_ok;
         logic [DIV_W-1:0] ld_div;

         if (!RST_DEC.ok) begin : g_bad_rst
            $error("tri_table_clkdiv: RST_CODE is not a valid code");
         end

         tcd_lut #(
            .KIND     (KIND),
            .DROP_LOW (SEC_DROP_LOW),
            .CODE_W   (CODE_W),
            .DIV_W    (DIV_W)
         ) u_lut (
            .code (cfg_wdata[LSB +: CODE_W]),
            .ok   (ld_ok),
            .div  (ld_div)
         );

         tcd_chan #(
            .DIV_W   (DIV_W),
            .RST_DIV (DIV_W'(RST_DEC.div))
         ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (cfg_we),
            .ld_ok  (ld_ok),
            .ld_div (ld_div),
            .tick   (ticks[i])
         );
      end
   endgenerate

   assign en_pri  = ticks[0];
   assign en_sec0 = ticks[1];
   assign en_sec1 = ticks[2];

   p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata == $past(cfg_wdata));

   p_reg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata));

endmodule

// File: tb/tb_tri_table_clkdiv.sv
`timescale 1ns/1ps
module tb_tri_table_clkdiv;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        we;
   logic [11:0] wdata;
   logic [11:0] rd_a, rd_b;
   logic        a_p, a_s0, a_s1, b_p, b_s0, b_s1;
   logic [5:0]  env;

   int n_chk  = 0;
   int n_fail = 0;
   int expd[6];
   bit inv[6];

   always #2.5 clk = ~clk;

   tri_table_clkdiv dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rd_a),
      .en_pri(a_p), .en_sec0(a_s0), .en_sec1(a_s1));

   tri_table_clkdiv #(.SEC_DROP_LOW(1'b1)) dut_skip (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rd_b),
      .en_pri(b_p), .en_sec0(b_s0), .en_sec1(b_s1));

   assign env = {b_s1, b_s0, b_p, a_s1, a_s0, a_p};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int pri_div(input int c);
      case (c)
         0: return 2;   1: return 3;   2: return 4;   3: return 6;
         4: return 8;   5: return 12;  6: return 16;  7: return 18;
         8: return 24;  10: return 36; 11: return 48;
         default: return 0;
      endcase
   endfunction

   function automatic int sec_div(input int c, input bit drop);
      case (c)
         4: return drop ? 0 : 8;
         5: return 12;  6: return 16;  7: return 18;  8: return 24;
         10: return 36; 11: return 48; 12: return 10;
         default: return 0;
      endcase
   endfunction

   task automatic write_word(input logic [11:0] w);
      @(negedge clk);
      we = 1'b1; wdata = w;
      @(negedge clk);
      we = 1'b0;
      chk(rd_a == w, "R1 readback", int'(rd_a), int'(w));
      chk(rd_b == w, "R1 readback skip", int'(rd_b), int'(w));
   endtask

   // Write, update the model, let every channel cross a boundary, then measure.
   task automatic apply(input logic [11:0] w);
      int last[6];
      int npul[6];
      int badg[6];
      write_word(w);
      for (int k = 0; k < 6; k++) begin
         int code = (int'(w) >> (8 - 4 * (k % 3))) & 15;   // R2 field position
         int d    = (k % 3 == 0) ? pri_div(code) : sec_div(code, k >= 3);
         inv[k] = (d == 0);
         if (d != 0) expd[k] = d;
         last[k] = -1; npul[k] = 0; badg[k] = 0;
      end
      repeat (50) @(negedge clk);
      for (int t = 0; t < 150; t++) begin
         @(negedge clk);
         for (int k = 0; k < 6; k++) begin
            if (env[k]) begin
               if (last[k] >= 0 && (t - last[k]) != expd[k] && badg[k] == 0)
                  badg[k] = t - last[k];
               last[k] = t;
               npul[k]++;
            end
         end
      end
      for (int k = 0; k < 6; k++) begin
         string req;
         if (inv[k])            req = "R6 invalid code keeps divisor";
         else if (k % 3 == 0)   req = "R3 primary period";
         else if (k >= 3)       req = "R5 secondary period (drop low)";
         else                   req = "R4 secondary period";
         chk(npul[k] >= 2 && badg[k] == 0, req,
             (badg[k] != 0) ? badg[k] : ((npul[k] >= 2) ? expd[k] : npul[k]), expd[k]);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int first[6];
      int second[6];
      rst_n = 1'b0; we = 1'b0; wdata = '0;
      for (int k = 0; k < 6; k++) begin expd[k] = 48; first[k] = -1; second[k] = -1; end
      repeat (3) @(negedge clk);
      chk(env == 6'b0, "R9 enables low in reset", int'(env), 0);
      chk(rd_a == 12'hBBB, "R1 reset word", int'(rd_a), 12'hBBB);
      chk(rd_b == 12'hBBB, "R1 reset word skip", int'(rd_b), 12'hBBB);
      rst_n = 1'b1;
      // t counts rising edges since release; a mid-period write lands at t=10.
      for (int t = 0; t < 120; t++) begin
         for (int k = 0; k < 6; k++) begin
            if (env[k]) begin
               if (first[k] < 0) first[k] = t;
               else if (second[k] < 0) second[k] = t;
            end
         end
         if (t == 10) begin we = 1'b1; wdata = 12'h0BB; end
         if (t == 11) we = 1'b0;
         @(negedge clk);
      end
      for (int k = 0; k < 6; k++)
         chk(first[k] == 47, "R9 first pulse after reset", first[k], 47);
      chk(second[0] == 49, "R8 primary old period completes", second[0], 49);
      chk(second[3] == 49, "R8 primary old period completes skip", second[3], 49);
      chk(second[1] == 95, "R7 secondary 48 period", second[1], 95);
      chk(second[5] == 95, "R7 secondary 48 period skip", second[5], 95);
      expd[0] = 2; expd[3] = 2;

      for (int c = 0; c < 16; c++) apply({4'(c), 4'(c), 4'(c)});
      apply(12'h5A6);   // R2: distinct fields 12 / 36 / 16
      apply(12'h2C4);   // R2: 4 / 10 / 8 (drop-low keeps 16)
      apply(12'hF9D);   // R6: all invalid, nothing changes
      apply(12'h1B0);   // R6: secondary 1 invalid, others change

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule